// File: doc/BRIEF.md
# Dual BCD Alarm Comparator with Per-Field Enables

This block holds no time itself. It watches a calendar clock that some other logic advances. It also reads two alarm register banks that software fills in. Each time the clock pulses its update strobe, the block compares the current packed-BCD time and date with each bank. A bank matches when at least one field is enabled and every enabled field equals the current time value. A match sets that bank's alarm flag, and the flag stays set until it is cleared.

Every alarm field carries its own enable bit. Software uses these bits to choose how often an alarm recurs. For example, it can enable month, date, hour, minute and second for a yearly alarm, or enable minute and second alone for an hourly one. Year takes no part in the match, and the alarm hour field has no 12/24-hour bit. The flags come out as two registered bits. Flag 0 is meant for status bit 5 and flag 1 for status bit 6 of a status register outside this block.

Top module: `alarm_comparator`

## Requirements
- R1: `time_regs` holds six bytes and `alarm_regs` holds twelve. Byte `f` of `time_regs` (bits 8f+7..8f) is field f, and byte `b*6+f` of `alarm_regs` is field f of bank b. The field order is 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week. Bit 7 of every alarm byte is that field's enable.
- R2: Only the value bits are compared. These are bits 6..0 for second and minute, bits 5..0 for hour and date, bits 4..0 for month and bits 2..0 for day of week. Alarm enable bits, unused bits and the 24-hour mode bit (bit 7 of the time hour byte) never affect a match.
- R3: A field whose enable bit is clear is ignored, whatever its value.
- R4: A bank with no enable bit set never matches.
- R5: When `tick` is high on a clock edge and a bank matches, that bank's `alarm_flag` bit is 1 after the edge. Without `tick`, a match sets nothing.
- R6: A set flag stays set until it is cleared, even if later updates no longer match.
- R7: `flag_clr[b]` high on an edge clears flag b after that edge. If a new match for the same bank arrives on the same edge, the set wins.
- R8: The two banks act independently. The comparison, the flag and the clear of one bank never touch the other.
- R9: Synchronous active-high `rst` clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse when the time value has updated |
| time_regs | input | 48 | Current time bytes, field f in byte f |
| alarm_regs | input | 96 | Alarm bank bytes, bank b field f in byte b*6+f |
| flag_clr | input | 2 | Per-bank flag clear |
| alarm_flag | output | 2 | Sticky alarm flags, bit 0 for bank 0 |

## Verification
The assertions take for granted that the alarm and time bytes are stable around each edge and that `rst` is high from time zero. They make no assumption about whether the BCD digits are legal, because the comparison works on raw masked bits. The random stimulus therefore drives arbitrary bytes. In about half of the cycles it copies the current time into a bank with random enables and single-field changes, so that hits, near misses and empty enable sets all occur. It also raises `tick` and `flag_clr` independently, so that a set and a clear sometimes land on the same edge.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;
  localparam int EN_BIT     = 7;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;

  // Value bits of each field that take part in a match
  function automatic logic [BYTE_W-1:0] field_mask(int idx);
    case (idx)
      FLD_SEC, FLD_MIN:   return 8'h7F;
      FLD_HOUR, FLD_DATE: return 8'h3F;
      FLD_MONTH:          return 8'h1F;
      default:            return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_cmp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MASK = 8'h7F
) (
  input  logic [BYTE_W-1:0] tm_byte,
  input  logic [BYTE_W-1:0] al_byte,
  output logic              en,
  output logic              eq
);
  always_comb begin
    en = al_byte[EN_BIT];
    eq = ((tm_byte ^ al_byte) & MASK) == '0;
  end
endmodule

// File: rtl/alarm_bank_match.sv
module alarm_bank_match
  import alarm_cmp_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic [NF*BYTE_W-1:0] time_bytes,
  input  logic [NF*BYTE_W-1:0] bank_bytes,
  output logic                 hit
);
  logic [NF-1:0] fld_en;
  logic [NF-1:0] fld_eq;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    alarm_field_cmp #(.MASK(field_mask(f))) u_cmp (
      .tm_byte (time_bytes[f*BYTE_W +: BYTE_W]),
      .al_byte (bank_bytes[f*BYTE_W +: BYTE_W]),
      .en      (fld_en[f]),
      .eq      (fld_eq[f])
    );
  end

  // every enabled field equal, and at least one field enabled
  always_comb hit = (&(fld_eq | ~fld_en)) & (|fld_en);
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  tick,
  input  logic [NUM_FIELDS*BYTE_W-1:0]          time_regs,
  input  logic [NUM_ALARMS*NUM_FIELDS*BYTE_W-1:0] alarm_regs,
  input  logic [NUM_ALARMS-1:0]                 flag_clr,
  output logic [NUM_ALARMS-1:0]                 alarm_flag
);
  localparam int BANK_W = NUM_FIELDS * BYTE_W;

  logic [NUM_ALARMS-1:0] bank_hit;

  for (genvar b = 0; b < NUM_ALARMS; b++) begin : g_bank
    alarm_bank_match #(.NF(NUM_FIELDS)) u_match (
      .time_bytes (time_regs),
      .bank_bytes (alarm_regs[b*BANK_W +: BANK_W]),
      .hit        (bank_hit[b])
    );
    alarm_flag_reg u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_req (tick & bank_hit[b]),
      .clr_req (flag_clr[b]),
      .flag    (alarm_flag[b])
    );
  end
endmodule

// File: rtl/alarm_comparator_chk.sv
module alarm_comparator_chk
  import alarm_cmp_pkg::*;
#(
  parameter int NA = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          tick,
  input logic [NA*NUM_FIELDS*BYTE_W-1:0] alarm_regs,
  input logic [NA-1:0]                 flag_clr,
  input logic [NA-1:0]                 bank_hit,
  input logic [NA-1:0]                 alarm_flag
);
  for (genvar b = 0; b < NA; b++) begin : g_chk
    logic [NUM_FIELDS-1:0] ens;
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_en
      assign ens[f] = alarm_regs[(b*NUM_FIELDS+f)*BYTE_W + EN_BIT];
    end

    a_r4_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
      (ens == '0) |-> !bank_hit[b]);

    a_r5_hit_sets: assert property (@(posedge clk) disable iff (rst)
      (tick && bank_hit[b]) |=> alarm_flag[b]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag[b] && !flag_clr[b]) |=> alarm_flag[b]);

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[b] && !(tick && bank_hit[b])) |=> !alarm_flag[b]);

    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (!alarm_flag[b] && !(tick && bank_hit[b])) |=> !alarm_flag[b]);
  end
endmodule

bind alarm_comparator alarm_comparator_chk #(.NA(NUM_ALARMS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .alarm_regs (alarm_regs),
  .flag_clr   (flag_clr),
  .bank_hit   (bank_hit),
  .alarm_flag (alarm_flag)
);

// File: tb/test_alarm_comparator.sv
module test_alarm_comparator;
  localparam int NF = 6;
  localparam int NA = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic [NF*8-1:0]   time_regs = '0;
  logic [NA*NF*8-1:0] alarm_regs = '0;
  logic [NA-1:0]     flag_clr = '0;
  logic [NA-1:0]     alarm_flag;

  int checks = 0;
  int errors = 0;
  logic [NA-1:0] exp_flag = '0;

  always #5 clk = ~clk;

  alarm_comparator i_alarm_comparator (
    .clk(clk), .rst(rst), .tick(tick), .time_regs(time_regs),
    .alarm_regs(alarm_regs), .flag_clr(flag_clr), .alarm_flag(alarm_flag)
  );

  function automatic logic [7:0] mask_of(int f);
    case (f)
      0, 1: return 8'h7F;
      2, 3: return 8'h3F;
      4:    return 8'h1F;
      default: return 8'h07;
    endcase
  endfunction

  function automatic logic model_hit(int b);
    logic any = 1'b0;
    logic ok = 1'b1;
    for (int f = 0; f < NF; f++) begin
      logic [7:0] a = alarm_regs[(b*NF+f)*8 +: 8];
      logic [7:0] t = time_regs[f*8 +: 8];
      if (a[7]) begin
        any = 1'b1;
        if ((a & mask_of(f)) != (t & mask_of(f))) ok = 1'b0;
      end
    end
    return any & ok;
  endfunction

  function automatic logic [NA-1:0] model_next();
    logic [NA-1:0] n = exp_flag;
    for (int b = 0; b < NA; b++) begin
      if (tick && model_hit(b)) n[b] = 1'b1;
      else if (flag_clr[b])     n[b] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(string req);
    checks++;
    if (alarm_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s: alarm_flag=%b expected=%b", req, alarm_flag, exp_flag);
    end
  endtask

  // inputs are set after a negedge; flags are compared at the following negedge
  task automatic step(string req);
    exp_flag = model_next();
    @(negedge clk);
    check(req);
    tick = 1'b0;
    flag_clr = '0;
  endtask

  task automatic set_field(int b, int f, logic [7:0] v);
    alarm_regs[(b*NF+f)*8 +: 8] = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    exp_flag = '0;
    check("R9 reset");
    rst = 1'b0;

    // Yearly alarm on bank 0: month/date/hour/min/sec enabled, dow differs (R1, R3)
    time_regs = {8'h03, 8'h12, 8'h25, 8'h17, 8'h45, 8'h30};
    for (int f = 0; f < 5; f++) set_field(0, f, 8'h80 | time_regs[f*8 +: 8]);
    set_field(0, 5, 8'h06);
    alarm_regs[NF*8 +: NF*8] = '0;
    step("R5 no tick no set");
    tick = 1'b1; step("R1 R3 yearly match sets flag 0");
    step("R6 flag holds");
    // change time so no match; flag sticks
    time_regs[0 +: 8] = 8'h31; tick = 1'b1; step("R6 sticky after mismatch");
    // empty bank 1 while time matches anything
    tick = 1'b1; step("R4 empty bank 1 stays clear");
    flag_clr = 2'b01; step("R7 clear flag 0");
    // unused bits: alarm sec with extra bits, time hour with 24h bit (R2)
    time_regs[0 +: 8] = 8'h30;
    time_regs[2*8 +: 8] = 8'h97;
    set_field(0, 0, 8'hB0);
    tick = 1'b1; step("R2 masked bits ignored");
    // simultaneous clear and match: set wins
    tick = 1'b1; flag_clr = 2'b01; step("R7 set wins over clear");
    // bank 1 dow-only alarm, bank 0 cleared independently (R8)
    set_field(1, 5, 8'h83); time_regs[5*8 +: 8] = 8'hF3;
    tick = 1'b1; flag_clr = 2'b01; step("R8 bank 1 sets, bank 0 set wins");
    flag_clr = 2'b01; step("R8 clear only bank 0");
    set_field(1, 5, 8'h84);
    tick = 1'b1; step("R3 enabled dow mismatch no set");
    flag_clr = 2'b10; step("R7 clear bank 1");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      time_regs = {$urandom(), $urandom()};
      for (int b = 0; b < NA; b++) begin
        for (int f = 0; f < NF; f++) begin
          logic [7:0] v = $urandom();
          if ($urandom_range(1, 0) == 1) begin
            v = {v[7], time_regs[f*8 +: 7]};
            if ($urandom_range(7, 0) == 0) v[6:0] = v[6:0] ^ mask_of(f)[6:0] & 7'(1 << $urandom_range(2, 0));
          end
          if ($urandom_range(9, 0) == 0) v[7] = 1'b0;
          set_field(b, f, v);
        end
      end
      tick = ($urandom_range(2, 0) != 0);
      flag_clr = NA'($urandom_range(3, 0) == 0 ? $urandom() : 0);
      step("R5/R6/R7 random");
    end

    rst = 1'b1;
    exp_flag = '0;
    @(negedge clk);
    check("R9 reset again");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    $urandom(32'd4021);
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule